// File: doc/BRIEF.md
# Branch Discontinuity Trace Recorder

This block keeps a record of program flow in a small on-chip ring of trace frames. It does not store every retired instruction. It stores a frame only when the retired PC breaks sequential flow. A break is a PC that differs from the previous retired PC plus the fixed instruction size, or a retirement that the core itself flags as redirected. Each flow frame holds the PC the core left from and the PC it arrived at. From these frames a debugger can rebuild the executed path once the core has halted.

A separate enable adds frames for load and store accesses, each holding the access address and its data. A gate input from the trigger unit switches capture on and off. Frames already in the ring stay there when the gate drops. The ring holds a fixed number of frames. When it is full, a new frame replaces the oldest one and a sticky flag records that history was lost. A debugger drains the ring through a read port that always shows the oldest unread frame. A pop strobe advances that port, and an empty indication rises when nothing is left to read.

Top module: `brtrace_rec`

## Requirements
- R1: After reset the ring is empty (`rd_empty` = 1) and `wrapped` = 0.
- R2: A retirement whose PC equals the previous retired PC plus INSN_BYTES, with `ret_redirect` low, writes no frame. The first retirement after reset never writes a frame.
- R3: A retirement whose PC differs from the previous retired PC plus INSN_BYTES, or one with `ret_redirect` high, writes a flow frame. The frame has kind 2'b00, `first` = the previous retired PC and `second` = the new PC.
- R4: With `ls_en` high, an access (`ls_valid`) writes a frame with `first` = `ls_addr` and `second` = `ls_data`. Its kind is 2'b01 when `ls_store` = 0 (load) and 2'b10 when `ls_store` = 1 (store). With `ls_en` low, accesses write nothing.
- R5: While `trace_gate` is low no frame is written and stored frames are kept. The previous-PC tracking still follows every retirement, so a sequential retirement right after the gate rises writes nothing.
- R6: When a flow frame and an access frame fall in the same cycle, only the flow frame is written.
- R7: The read port shows the oldest unread frame. `rd_pop` with a frame present removes it. `rd_empty` rises once all frames are read. `rd_pop` on an empty ring has no effect.
- R8: Writing to a full ring (DEPTH frames) without a pop overwrites the oldest frame and sets `wrapped`, which stays set until reset.
- R9: A pop and a write in the same cycle on a full ring removes the oldest frame, stores the new one and leaves `wrapped` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_pc | input | W | PC of the retiring instruction |
| ret_redirect | input | 1 | The core flags this retirement as a flow break |
| ls_valid | input | 1 | A load or store access is presented |
| ls_store | input | 1 | 1 = store, 0 = load |
| ls_addr | input | W | Access address |
| ls_data | input | W | Access data |
| ls_en | input | 1 | Enables access frames |
| trace_gate | input | 1 | Capture gate from the trigger unit |
| rd_pop | input | 1 | Remove the oldest frame |
| rd_empty | output | 1 | No unread frame |
| rd_kind | output | 2 | Kind of the oldest frame |
| rd_first | output | W | Source PC or access address |
| rd_second | output | W | Target PC or access data |
| wrapped | output | 1 | Sticky: a frame was overwritten |

## Verification
The hardest situation to reach is a full ring that receives a write and a pop in the same edge. That case has to leave `wrapped` low, and a flag already set by earlier overflow would hide any mistake. The bench therefore resets the block again and fills it to exactly DEPTH frames with a chain of jumps. It then drives pops and jumps together and compares the oldest frame and the flag against a queue model on every clock. Long randomized runs, which mix gating, coincident accesses and pops, cover the remaining orderings.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;
    typedef enum logic [1:0] {
        FK_FLOW  = 2'b00,
        FK_LOAD  = 2'b01,
        FK_STORE = 2'b10
    } frame_kind_e;
endpackage

// File: rtl/brtrace_flow.sv
module brtrace_flow #(
    parameter int W          = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ret_valid,
    input  logic [W-1:0] ret_pc,
    input  logic         ret_redirect,
    output logic         hit,
    output logic [W-1:0] src_pc
);
    localparam logic [W-1:0] STEP = W'(INSN_BYTES);

    typedef struct packed {
        logic [W-1:0] prev;
        logic         seen;
    } flow_st_t;

    flow_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        hit    = 1'b0;
        src_pc = s_q.prev;
        if (ret_valid) begin
            hit    = s_q.seen && (ret_redirect || (ret_pc != s_q.prev + STEP));
            s_d.prev = ret_pc;
            s_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_prev_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> (s_q.prev == $past(ret_pc)) && s_q.seen);
    p_hit_needs_retire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ret_valid && s_q.seen);
endmodule

// File: rtl/brtrace_ring.sv
module brtrace_ring #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_kind,
    input  logic [W-1:0] wr_a,
    input  logic [W-1:0] wr_b,
    input  logic         rd_pop,
    output logic         rd_empty,
    output logic [1:0]   rd_kind,
    output logic [W-1:0] rd_a,
    output logic [W-1:0] rd_b,
    output logic         wrapped
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;
    localparam int FW = 2 + 2 * W;
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wr_ptr;
        logic [CW-1:0] count;
        logic          wrapped;
    } ring_st_t;

    ring_st_t s_d, s_q;
    logic [FW-1:0] mem_q [DEPTH];
    logic [PW-1:0] rd_idx;
    logic          pop_ok;
    logic          full;

    always_comb begin
        s_d    = s_q;
        full   = (s_q.count == FULL);
        pop_ok = rd_pop && (s_q.count != '0);
        rd_idx = s_q.wr_ptr - s_q.count[PW-1:0];
        if (wr_en) s_d.wr_ptr = s_q.wr_ptr + 1'b1;
        if (wr_en && !pop_ok) begin
            if (full) s_d.wrapped = 1'b1;
            else      s_d.count   = s_q.count + 1'b1;
        end else if (!wr_en && pop_ok) begin
            s_d.count = s_q.count - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[s_q.wr_ptr] <= {wr_kind, wr_a, wr_b};
    end

    assign rd_empty = (s_q.count == '0);
    assign rd_kind  = mem_q[rd_idx][FW-1 -: 2];
    assign rd_a     = mem_q[rd_idx][2*W-1 -: W];
    assign rd_b     = mem_q[rd_idx][W-1:0];
    assign wrapped  = s_q.wrapped;

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.count <= FULL);
    p_full_write_wraps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_pop) |=> wrapped && (s_q.count == FULL));
    p_wrapped_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wrapped |=> wrapped);
    p_empty_pop_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_empty && rd_pop && !wr_en) |=> rd_empty);
    p_full_pop_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && rd_pop) |=> (s_q.count == FULL) && $stable(wrapped));
endmodule

// File: rtl/brtrace_rec.sv
module brtrace_rec
    import brtrace_pkg::*;
#(
    parameter int W          = 32,
    parameter int DEPTH      = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ret_valid,
    input  logic [W-1:0] ret_pc,
    input  logic         ret_redirect,
    input  logic         ls_valid,
    input  logic         ls_store,
    input  logic [W-1:0] ls_addr,
    input  logic [W-1:0] ls_data,
    input  logic         ls_en,
    input  logic         trace_gate,
    input  logic         rd_pop,
    output logic         rd_empty,
    output logic [1:0]   rd_kind,
    output logic [W-1:0] rd_first,
    output logic [W-1:0] rd_second,
    output logic         wrapped
);
    logic         flow_hit;
    logic [W-1:0] flow_src;
    logic         wr_en_d;
    frame_kind_e  wr_kind_d;
    logic [W-1:0] wr_a_d, wr_b_d;

    brtrace_flow #(.W(W), .INSN_BYTES(INSN_BYTES)) flow_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ret_valid    (ret_valid),
        .ret_pc       (ret_pc),
        .ret_redirect (ret_redirect),
        .hit          (flow_hit),
        .src_pc       (flow_src)
    );

    always_comb begin
        wr_en_d   = 1'b0;
        wr_kind_d = FK_FLOW;
        wr_a_d    = flow_src;
        wr_b_d    = ret_pc;
        if (trace_gate) begin
            if (flow_hit) begin
                wr_en_d = 1'b1;
            end else if (ls_en && ls_valid) begin
                wr_en_d   = 1'b1;
                wr_kind_d = ls_store ? FK_STORE : FK_LOAD;
                wr_a_d    = ls_addr;
                wr_b_d    = ls_data;
            end
        end
    end

    brtrace_ring #(.W(W), .DEPTH(DEPTH)) ring_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_d),
        .wr_kind  (wr_kind_d),
        .wr_a     (wr_a_d),
        .wr_b     (wr_b_d),
        .rd_pop   (rd_pop),
        .rd_empty (rd_empty),
        .rd_kind  (rd_kind),
        .rd_a     (rd_first),
        .rd_b     (rd_second),
        .wrapped  (wrapped)
    );

    p_gate_low_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_gate |-> !wr_en_d);
    p_flow_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_hit && trace_gate && ls_en && ls_valid) |-> wr_en_d && (wr_kind_d == FK_FLOW));
    p_ls_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ls_en && !flow_hit) |-> !wr_en_d);
endmodule

// File: tb/brtrace_rec_tb_top.sv
module brtrace_rec_tb_top;
    localparam int W = 32;
    localparam int DEPTH = 8;
    localparam int STEP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ret_valid = 0, ret_redirect = 0, ls_valid = 0, ls_store = 0;
    logic ls_en = 0, trace_gate = 0, rd_pop = 0;
    logic [W-1:0] ret_pc = '0, ls_addr = '0, ls_data = '0;
    logic rd_empty, wrapped;
    logic [1:0] rd_kind;
    logic [W-1:0] rd_first, rd_second;

    int checks = 0;
    int fails = 0;

    typedef struct {
        logic [1:0]   k;
        logic [W-1:0] a;
        logic [W-1:0] b;
    } mfr_t;
    mfr_t mq[$];
    bit m_wrapped = 0;
    bit m_seen = 0;
    logic [W-1:0] m_prev = '0;

    always #10 clk = ~clk;

    brtrace_rec #(.W(W), .DEPTH(DEPTH), .INSN_BYTES(STEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .ret_redirect(ret_redirect), .ls_valid(ls_valid), .ls_store(ls_store),
        .ls_addr(ls_addr), .ls_data(ls_data), .ls_en(ls_en),
        .trace_gate(trace_gate), .rd_pop(rd_pop), .rd_empty(rd_empty),
        .rd_kind(rd_kind), .rd_first(rd_first), .rd_second(rd_second),
        .wrapped(wrapped)
    );

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "rd_empty", W'(rd_empty), W'(mq.size() == 0));
        check(tag, "wrapped", W'(wrapped), W'(m_wrapped));
        if (mq.size() != 0) begin
            check(tag, "rd_kind", W'(rd_kind), W'(mq[0].k));
            check(tag, "rd_first", rd_first, mq[0].a);
            check(tag, "rd_second", rd_second, mq[0].b);
        end
    endtask

    task automatic model_edge();
        bit flow, wr;
        mfr_t f;
        flow = ret_valid && m_seen &&
               (ret_redirect || (ret_pc != m_prev + W'(STEP)));
        wr = 0;
        if (trace_gate && flow) begin
            wr = 1; f.k = 2'b00; f.a = m_prev; f.b = ret_pc;
        end else if (trace_gate && ls_en && ls_valid) begin
            wr = 1; f.k = ls_store ? 2'b10 : 2'b01; f.a = ls_addr; f.b = ls_data;
        end
        if (rd_pop && mq.size() != 0) void'(mq.pop_front());
        if (wr) begin
            if (mq.size() == DEPTH) begin
                void'(mq.pop_front());
                m_wrapped = 1;
            end
            mq.push_back(f);
        end
        if (ret_valid) begin
            m_prev = ret_pc;
            m_seen = 1;
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        compare(tag);
    endtask

    task automatic idle();
        ret_valid = 0; ret_redirect = 0; ls_valid = 0; rd_pop = 0;
    endtask

    task automatic retire(input logic [W-1:0] pc, input logic redir, input string tag);
        idle(); ret_valid = 1; ret_pc = pc; ret_redirect = redir;
        cyc(tag);
        idle();
    endtask

    task automatic access(input logic st, input logic [W-1:0] a,
                          input logic [W-1:0] d, input string tag);
        idle(); ls_valid = 1; ls_store = st; ls_addr = a; ls_data = d;
        cyc(tag);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (2) @(posedge clk);
        #1;
        mq.delete(); m_wrapped = 0; m_seen = 0; m_prev = '0;
        rst_n = 1;
        compare("R1");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] p;
        #5;
        do_reset();
        check("R1", "reset empty", W'(rd_empty), 1);
        check("R1", "reset wrapped", W'(wrapped), 0);

        trace_gate = 1;
        for (int i = 0; i < 6; i++) retire(32'h100 + 4 * i, 0, "R2");
        check("R2", "sequential run leaves ring empty", W'(rd_empty), 1);

        retire(32'h200, 0, "R3");
        check("R3", "flow source", rd_first, 32'h114);
        check("R3", "flow target", rd_second, 32'h200);
        check("R3", "flow kind", W'(rd_kind), 0);
        retire(32'h204, 1, "R3");

        ls_en = 1;
        access(0, 32'hA000, 32'h1111, "R4");
        access(1, 32'hA004, 32'h2222, "R4");
        ls_en = 0;
        access(1, 32'hA008, 32'h3333, "R4");

        trace_gate = 0;
        retire(32'h400, 0, "R5");
        ls_en = 1;
        access(0, 32'hB000, 32'h4444, "R5");
        trace_gate = 1;
        retire(32'h404, 0, "R5");
        check("R5", "frames kept and nothing added", W'(mq.size()), 4);

        idle(); ret_valid = 1; ret_pc = 32'h800; ls_valid = 1; ls_store = 1;
        ls_addr = 32'hC000; ls_data = 32'h5555;
        cyc("R6");
        idle();
        check("R6", "newest frame count", W'(mq.size()), 5);
        check("R6", "newest frame is flow", W'(mq[4].k), 0);
        ls_en = 0;

        for (int i = 0; i < 7; i++) begin
            idle(); rd_pop = 1; cyc("R7");
        end
        idle();
        check("R7", "drained empty", W'(rd_empty), 1);

        for (int i = 0; i < 12; i++) retire(32'h1000 + 32'h100 * i, 0, "R8");
        check("R8", "wrapped set", W'(wrapped), 1);
        check("R8", "oldest surviving source", rd_first, 32'h1300);
        for (int i = 0; i < 9; i++) begin
            idle(); rd_pop = 1; cyc("R8");
        end
        idle();
        check("R8", "wrapped sticky after drain", W'(wrapped), 1);

        do_reset();
        trace_gate = 1;
        retire(32'h40, 0, "R9");
        for (int i = 0; i < DEPTH; i++) retire(32'h2000 + 32'h100 * i, 0, "R9");
        for (int i = 0; i < 3; i++) begin
            idle(); ret_valid = 1; ret_pc = 32'h9000 + 32'h100 * i; rd_pop = 1;
            cyc("R9");
        end
        idle();
        check("R9", "no wrap on full pop+write", W'(wrapped), 0);
        check("R9", "oldest after pop+write", rd_first, 32'h2200);

        p = 32'h3000;
        for (int i = 0; i < 600; i++) begin
            idle();
            ret_valid = $urandom_range(0, 3) != 0;
            p = ($urandom_range(0, 4) == 0) ? ($urandom() & 32'hFFFC) : p + 4;
            ret_pc = p;
            ret_redirect = $urandom_range(0, 15) == 0;
            ls_valid = $urandom_range(0, 2) == 0;
            ls_store = $urandom_range(0, 1);
            ls_addr = $urandom();
            ls_data = $urandom();
            ls_en = $urandom_range(0, 3) != 0;
            trace_gate = $urandom_range(0, 5) != 0;
            rd_pop = $urandom_range(0, 2) == 0;
            cyc("R7");
        end
        idle();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule